// File: doc/BRIEF.md
# Keyed Watchdog Timer with Selectable Expiry Event

This block is a register-mapped watchdog. Software places a period, counted in system clock cycles, into a 32-bit period register and starts the timer by writing an enable key into the control word. The key has one disarm value; every other key value arms the timer. While armed, a 32-bit countdown register decrements once per clock. Software keeps the system alive by writing anything to the countdown register, which reloads it from the period register.

When the countdown steps from one to zero, a sticky expired flag is set in the control word and one event is raised, chosen by a two-bit selector: a single-cycle reset pulse, a non-maskable interrupt request, a general-purpose interrupt request, or no event at all. The interrupt requests stay high as long as the flag stays set. Software acknowledges by writing the disarm key, a one in the flag position and the "no event" selector in a single control write. Reaching zero does not stop the timer: the countdown sits at zero until it is reloaded or the timer is disarmed.

The register bus is a single-cycle write strobe with a word select and a combinational read port. Word select 0 is control, 1 is the period, 2 is the countdown.

Top module: `kwd_top`

## Requirements
- R1: After reset the control word reads 0x0000_0AD0 (disarm key 0xAD in bits 11:4, selector 00, flag 0), the period and countdown registers read 0, and all three event outputs are low.
- R2: A control write stores bits 11:4 as the key and bits 2:1 as the selector; reading the control word returns the flag in bit 15, the key in bits 11:4, the selector in bits 2:1 and zeros elsewhere.
- R3: While the key equals 0xAD, the countdown register keeps its value on every cycle with no bus write.
- R4: A control write that changes the key from 0xAD to any other value loads the countdown from the period register; while armed and non-zero, the countdown then decreases by one per clock.
- R5: A write of any data to the countdown register (word select 2) loads it from the period register.
- R6: When the armed countdown steps from 1 to 0, the flag in control bit 15 is set; it stays set, and the countdown stays at 0, until software acts.
- R7: A control write with bit 15 at 1 clears the flag; a control write with bit 15 at 0 leaves it unchanged.
- R8: With selector 00, the reset output is high for exactly the one cycle in which the flag becomes set.
- R9: With the flag set, selector 01 drives the non-maskable request high, selector 10 drives the general-purpose request high, selector 11 drives no output; at most one output is high at any time.
- R10: An armed timer whose countdown is loaded with a period of 0 never sets the flag.
- R11: The period register (word select 1) stores and returns a full 32-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 2 | Word select: 0 control, 1 period, 2 countdown |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the selected word |
| rstPulse | output | 1 | One-cycle reset request at expiry |
| nmiReq | output | 1 | Non-maskable interrupt request, level |
| gpiReq | output | 1 | General-purpose interrupt request, level |

## Verification
A countdown that slips by one cycle moves the expiry edge, so the event outputs and the control flag read at the predicted cycle disagree with the bench within a few clocks of the expected expiry. A wrongly decoded key shows as a countdown that either keeps moving while disarmed or fails to reload on arming, visible on the next read of word 2. A flag that fails to stick or clears on a zero write is visible on the very next control read, and a selector mis-decode raises the wrong output in the same cycle the flag sets.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  // Control word field positions (software decodes these)
  localparam int FLAG_BIT = 15;
  localparam int KEY_LSB  = 4;
  localparam int KEY_W    = 8;
  localparam int SEL_LSB  = 1;
  localparam int SEL_W    = 2;

  typedef enum logic [1:0] {
    EV_RESET = 2'b00,
    EV_NMI   = 2'b01,
    EV_GPI   = 2'b10,
    EV_NONE  = 2'b11
  } evsel_e;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_COUNT  = 2'd2
  } regsel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCount;   // reload countdown from period
    logic countEn;     // timer armed
    logic writePeriod; // capture bus data into period register
  } strobe_t;

endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter logic [KEY_W-1:0] KEY_DISABLE = 8'hAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              hitZero,
  input  logic [DATA_W-1:0] periodVal,
  input  logic [DATA_W-1:0] countVal,
  output strobe_t           strobe,
  output logic [KEY_W-1:0]  enKey,
  output evsel_e            evSel,
  output logic              expired,
  output logic [DATA_W-1:0] busRdata
);

  logic             wrCtrl;
  logic             wrPeriod;
  logic             wrCount;
  logic             armed;
  logic             arming;
  logic [KEY_W-1:0] newKey;
  logic [DATA_W-1:0] ctrlWord;

  assign wrCtrl   = busWr && (busAddr == REG_CTRL);
  assign wrPeriod = busWr && (busAddr == REG_PERIOD);
  assign wrCount  = busWr && (busAddr == REG_COUNT);

  assign newKey = busWdata[KEY_LSB +: KEY_W];
  assign armed  = (enKey != KEY_DISABLE);
  assign arming = wrCtrl && !armed && (newKey != KEY_DISABLE);

  always_comb begin
    strobe.loadCount   = arming || wrCount;
    strobe.countEn     = armed;
    strobe.writePeriod = wrPeriod;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enKey   <= KEY_DISABLE;
      evSel   <= EV_RESET;
      expired <= 1'b0;
    end else begin
      if (wrCtrl) begin
        enKey <= newKey;
        evSel <= evsel_e'(busWdata[SEL_LSB +: SEL_W]);
      end
      // expiry takes priority over a simultaneous clear
      if (hitZero) begin
        expired <= 1'b1;
      end else if (wrCtrl && busWdata[FLAG_BIT]) begin
        expired <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrlWord                     = '0;
    ctrlWord[FLAG_BIT]           = expired;
    ctrlWord[KEY_LSB +: KEY_W]   = enKey;
    ctrlWord[SEL_LSB +: SEL_W]   = evSel;
  end

  always_comb begin
    case (busAddr)
      REG_CTRL:   busRdata = ctrlWord;
      REG_PERIOD: busRdata = periodVal;
      REG_COUNT:  busRdata = countVal;
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] periodVal,
  output logic [DATA_W-1:0] countVal,
  output logic              hitZero
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic countNonZero;

  assign countNonZero = (countVal != '0);
  // reload wins over the final decrement
  assign hitZero = strobe.countEn && !strobe.loadCount && (countVal == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodVal <= '0;
    end else if (strobe.writePeriod) begin
      periodVal <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobe.loadCount) begin
      countVal <= periodVal;
    end else if (strobe.countEn && countNonZero) begin
      countVal <= countVal - ONE;
    end
  end

endmodule

// File: rtl/kwd_events.sv
module kwd_events
  import kwd_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   hitZero,
  input  logic   expired,
  input  evsel_e evSel,
  output logic   rstPulse,
  output logic   nmiReq,
  output logic   gpiReq
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstPulse <= 1'b0;
    end else begin
      rstPulse <= hitZero && (evSel == EV_RESET);
    end
  end

  assign nmiReq = expired && (evSel == EV_NMI);
  assign gpiReq = expired && (evSel == EV_GPI);

endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter logic [KEY_W-1:0] KEY_DISABLE = 8'hAD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              rstPulse,
  output logic              nmiReq,
  output logic              gpiReq
);

  strobe_t           strobe;
  logic [KEY_W-1:0]  enKey;
  evsel_e            evSel;
  logic              expired;
  logic              hitZero;
  logic [DATA_W-1:0] periodVal;
  logic [DATA_W-1:0] countVal;

  kwd_ctrl #(.DATA_W(DATA_W), .KEY_DISABLE(KEY_DISABLE)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .hitZero   (hitZero),
    .periodVal (periodVal),
    .countVal  (countVal),
    .strobe    (strobe),
    .enKey     (enKey),
    .evSel     (evSel),
    .expired   (expired),
    .busRdata  (busRdata)
  );

  kwd_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .periodVal (periodVal),
    .countVal  (countVal),
    .hitZero   (hitZero)
  );

  kwd_events u_ev (
    .clk      (clk),
    .rstN     (rstN),
    .hitZero  (hitZero),
    .expired  (expired),
    .evSel    (evSel),
    .rstPulse (rstPulse),
    .nmiReq   (nmiReq),
    .gpiReq   (gpiReq)
  );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter logic [KEY_W-1:0] KEY_DISABLE = 8'hAD
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              rstPulse,
  input logic              nmiReq,
  input logic              gpiReq,
  input logic [KEY_W-1:0]  enKey,
  input logic [1:0]        evSel,
  input logic              expired,
  input logic [DATA_W-1:0] countVal
);

  assert_hold_disarmed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enKey == KEY_DISABLE && !busWr) |=> $stable(countVal));

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enKey != KEY_DISABLE && countVal != '0 && !busWr)
      |=> (countVal == $past(countVal) - DATA_W'(1)));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (expired && !busWr) |=> expired);

  assert_zero_parks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (countVal == '0 && !busWr) |=> (countVal == '0));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |=> !rstPulse);

  assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> (expired && evSel == 2'b00));

  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rstPulse, nmiReq, gpiReq}));

  assert_nmi_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    (expired && evSel == 2'b01) |-> nmiReq);

endmodule

bind kwd_top kwd_checker #(.DATA_W(DATA_W), .KEY_DISABLE(KEY_DISABLE)) u_chk (.*);

// File: tb/sim_kwd_top.sv
module sim_kwd_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_WAIT = 2'd2, OP_PIN = 2'd3;
  localparam logic [1:0] A_CTRL = 2'd0, A_PER = 2'd1, A_CNT = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [31:0] data;  // write data or wait cycles
    logic [31:0] exp;   // read value, or pins {rstPulse,nmiReq,gpiReq}
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 60;
  localparam vec_t VECS [NVEC] = '{
    '{OP_RD,  A_CTRL, 32'h0,      32'h0AD0, 8'd1},  // R1
    '{OP_RD,  A_CNT,  32'h0,      32'h0,    8'd1},  // R1
    '{OP_PIN, A_CTRL, 32'h0,      32'h0,    8'd1},  // R1
    '{OP_WR,  A_PER,  32'd5,      32'h0,    8'd0},
    '{OP_RD,  A_PER,  32'h0,      32'd5,    8'd11}, // R11
    '{OP_WR,  A_CTRL, 32'h0002,   32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd5,    8'd4},  // R4
    '{OP_RD,  A_CTRL, 32'h0,      32'h0002, 8'd2},  // R2
    '{OP_WAIT,A_CTRL, 32'd2,      32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd3,    8'd4},  // R4
    '{OP_WR,  A_CNT,  32'hDEAD,   32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd5,    8'd5},  // R5
    '{OP_WAIT,A_CTRL, 32'd5,      32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd0,    8'd6},  // R6
    '{OP_RD,  A_CTRL, 32'h0,      32'h8002, 8'd6},  // R6
    '{OP_PIN, A_CTRL, 32'h0,      32'd2,    8'd9},  // R9
    '{OP_WAIT,A_CTRL, 32'd3,      32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd0,    8'd6},  // R6
    '{OP_PIN, A_CTRL, 32'h0,      32'd2,    8'd9},  // R9
    '{OP_WR,  A_CTRL, 32'h0002,   32'h0,    8'd0},
    '{OP_RD,  A_CTRL, 32'h0,      32'h8002, 8'd7},  // R7
    '{OP_WR,  A_CTRL, 32'h8AD6,   32'h0,    8'd0},
    '{OP_RD,  A_CTRL, 32'h0,      32'h0AD6, 8'd7},  // R7
    '{OP_PIN, A_CTRL, 32'h0,      32'd0,    8'd9},  // R9
    '{OP_WR,  A_PER,  32'd3,      32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd0,    8'd3},  // R3
    '{OP_WR,  A_CTRL, 32'h0044,   32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd3,    8'd4},  // R4
    '{OP_RD,  A_CTRL, 32'h0,      32'h0044, 8'd2},  // R2
    '{OP_WAIT,A_CTRL, 32'd1,      32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd2,    8'd4},  // R4
    '{OP_WR,  A_CTRL, 32'h0AD4,   32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd1,    8'd3},  // R3
    '{OP_WAIT,A_CTRL, 32'd4,      32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd1,    8'd3},  // R3
    '{OP_WR,  A_CTRL, 32'h0044,   32'h0,    8'd0},
    '{OP_RD,  A_CNT,  32'h0,      32'd3,    8'd4},  // R4
    '{OP_WAIT,A_CTRL, 32'd3,      32'h0,    8'd0},
    '{OP_PIN, A_CTRL, 32'h0,      32'd1,    8'd9},  // R9
    '{OP_RD,  A_CTRL, 32'h0,      32'h8044, 8'd6},  // R6
    '{OP_WR,  A_CTRL, 32'h8AD6,   32'h0,    8'd0},
    '{OP_WR,  A_PER,  32'd2,      32'h0,    8'd0},
    '{OP_WR,  A_CTRL, 32'h0000,   32'h0,    8'd0},
    '{OP_WAIT,A_CTRL, 32'd2,      32'h0,    8'd0},
    '{OP_PIN, A_CTRL, 32'h0,      32'd4,    8'd8},  // R8
    '{OP_WAIT,A_CTRL, 32'd1,      32'h0,    8'd0},
    '{OP_PIN, A_CTRL, 32'h0,      32'd0,    8'd8},  // R8
    '{OP_RD,  A_CTRL, 32'h0,      32'h8000, 8'd6},  // R6
    '{OP_WR,  A_CTRL, 32'h8AD6,   32'h0,    8'd0},
    '{OP_WR,  A_PER,  32'd0,      32'h0,    8'd0},
    '{OP_WR,  A_CTRL, 32'h0006,   32'h0,    8'd0},
    '{OP_WAIT,A_CTRL, 32'd5,      32'h0,    8'd0},
    '{OP_RD,  A_CTRL, 32'h0,      32'h0006, 8'd10}, // R10
    '{OP_WR,  A_PER,  32'd1,      32'h0,    8'd0},
    '{OP_WR,  A_CNT,  32'h0,      32'h0,    8'd0},
    '{OP_WAIT,A_CTRL, 32'd1,      32'h0,    8'd0},
    '{OP_RD,  A_CTRL, 32'h0,      32'h8006, 8'd6},  // R6
    '{OP_PIN, A_CTRL, 32'h0,      32'd0,    8'd9},  // R9
    '{OP_WR,  A_CTRL, 32'h7AD9,   32'h0,    8'd0},
    '{OP_RD,  A_CTRL, 32'h0,      32'h8AD0, 8'd2}   // R2
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          busWr;
  logic [1:0]    busAddr;
  logic [DW-1:0] busWdata;
  logic [DW-1:0] busRdata;
  logic          rstPulse, nmiReq, gpiReq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwd_top u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .rstPulse(rstPulse), .nmiReq(nmiReq), .gpiReq(gpiReq)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic doRead(input logic [1:0] a, input logic [31:0] exp, input int req);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    rstN = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        OP_WR:   doWrite(VECS[i].addr, VECS[i].data);
        OP_RD:   doRead(VECS[i].addr, VECS[i].exp, int'(VECS[i].req));
        OP_WAIT: repeat (int'(VECS[i].data)) @(negedge clk);
        default: begin
          #1;
          check(int'(VECS[i].req), {29'b0, rstPulse, nmiReq, gpiReq}, VECS[i].exp);
        end
      endcase
    end

    // Directed: reset in the middle of an armed countdown returns to R1 state
    doWrite(A_PER, 32'd100);
    doWrite(A_CTRL, 32'h0002);
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doRead(A_CTRL, 32'h0AD0, 1);  // R1
    doRead(A_CNT, 32'h0, 1);      // R1
    doRead(A_PER, 32'h0, 1);      // R1
    #1;
    check(1, {29'b0, rstPulse, nmiReq, gpiReq}, 32'h0);  // R1

    // Directed: full-width period value, R11
    doWrite(A_PER, 32'hFFFF_FFFE);
    doRead(A_PER, 32'hFFFF_FFFE, 11);  // R11
    doWrite(A_CTRL, 32'h0016);          // key 0x01 arms, selector 11
    doRead(A_CNT, 32'hFFFF_FFFE, 4);   // R4
    repeat (2) @(negedge clk);
    doRead(A_CNT, 32'hFFFF_FFFC, 4);   // R4

    finish();
  end

endmodule